// File: doc/BRIEF.md
# End-of-Interrupt Write Handler

This block receives the 64-bit end-of-interrupt writes that a processor issues when it has finished servicing a group 0 interrupt. It turns each write into a priority-drop action, or into a priority drop plus a deactivation. The split depends on one mode bit. That bit is picked from four configuration bits using the writer's current privilege level, its security state and whether the highest privilege level exists.

The interrupt ID sits in the low 24 bits of the write. The upper bits are reserved and are ignored. A configuration input selects either a 16-bit or a 24-bit implemented ID width. IDs 1020 to 1023, compared after masking, are special, and a write that carries one is dropped entirely.

An acknowledge-tracking input loads the most recent valid acknowledged ID. Each end-of-interrupt write is compared with that ID. A write that does not match, or that arrives after the tracked ID has already been consumed, still performs its actions but raises a sticky mismatch flag.

Top module: `eoi_write_ctrl`

## Requirements
- R1: For each accepted write (`wr_valid` high with a non-special ID), `drop_valid` is high for exactly one cycle, in the cycle after the write, and `drop_id` carries the masked ID.
- R2: Write data bits 63:24 have no effect on any output.
- R3: With `id_wide`=0, ID bits 23:16 are treated as zero in writes and acknowledges, and `drop_id`/`deact_id` bits 23:16 are zero. With `id_wide`=1, all 24 bits are used.
- R4: When the selected mode bit is 0, `deact_valid` pulses in the same cycle as `drop_valid`, with the same ID.
- R5: When the selected mode bit is 1, only `drop_valid` pulses and `deact_valid` stays low.
- R6: With `top_present`=0, the selected mode bit is `mode_plain`. With `top_present`=1 and `cur_lvl`=3, it is `mode_top`.
- R7: With `top_present`=1 and `cur_lvl`≠3, the selected mode bit is `mode_sec` when `sec_state`=1 and `mode_nsec` when `sec_state`=0.
- R8: A write whose masked ID is in 1020..1023 produces no strobe. It also does not set the mismatch flag and does not change the tracked acknowledge. An ID such as 0x103FC in 24-bit mode is not special.
- R9: A write whose masked ID differs from the tracked ID, or that arrives when no ID is tracked, still performs its actions. In the same cycle as the strobes, `mismatch_err` is set, and it stays set until reset.
- R10: An accepted write consumes the tracked ID, so a further write before a new acknowledge is a mismatch. An `ack_valid` whose masked ID is special leaves the tracked state unchanged. An acknowledge in the same cycle as a write takes effect after that write.
- R11: After reset, all strobes, IDs and `mismatch_err` are zero, and no acknowledged ID is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | End-of-interrupt write strobe |
| wr_data | input | 64 | Write data; ID in bits 23:0 |
| cur_lvl | input | 2 | Current privilege level of the writer (3 = highest) |
| sec_state | input | 1 | Writer security state, 1 = secure |
| top_present | input | 1 | Highest privilege level is implemented |
| id_wide | input | 1 | 1 = 24-bit IDs, 0 = 16-bit IDs |
| mode_plain | input | 1 | Mode bit used when no highest level exists |
| mode_top | input | 1 | Mode bit used at the highest level |
| mode_sec | input | 1 | Mode bit for secure lower levels |
| mode_nsec | input | 1 | Mode bit for non-secure lower levels |
| ack_valid | input | 1 | An acknowledge read returned `ack_id` |
| ack_id | input | 24 | ID returned by that acknowledge |
| drop_valid | output | 1 | Priority-drop strobe |
| drop_id | output | 24 | ID for the priority drop |
| deact_valid | output | 1 | Deactivate strobe |
| deact_id | output | 24 | ID for the deactivation |
| mismatch_err | output | 1 | Sticky mismatch error |

## Verification
Every cycle, the assertions check these properties:
- A deactivation never appears without a matching priority drop.
- Each drop follows a write.
- Special IDs never produce a strobe.
- Narrow mode keeps the upper ID bits at zero.
- The mismatch flag, once set, stays set.
- The tracked ID is consumed by each accepted write.

Some properties can only be shown by the bench scenarios: that the right mode bit is picked for each combination of level, security state and presence of the highest level, and that the reserved bits are ignored. The scenarios also show when a mismatch is flagged, including a special acknowledge that leaves the tracker alone.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

    localparam int EOI_DATA_W   = 64;
    localparam int EOI_ID_W     = 24;
    localparam int EOI_NARROW_W = 16;
    localparam int SPECIAL_LO   = 1020;
    localparam int SPECIAL_HI   = 1023;
    localparam logic [1:0] TOP_LVL = 2'd3;

    typedef struct packed {
        logic [EOI_ID_W-1:0] id;
        logic                special;
    } id_info_t;

    typedef struct packed {
        logic                valid;
        logic                deact;
        logic [EOI_ID_W-1:0] id;
    } eoi_act_t;

    function automatic logic id_is_special(input logic [EOI_ID_W-1:0] id);
        return (id >= EOI_ID_W'(SPECIAL_LO)) && (id <= EOI_ID_W'(SPECIAL_HI));
    endfunction

endpackage

// File: rtl/eoi_id_decode.sv
module eoi_id_decode
    import eoi_pkg::*;
#(
    parameter int ID_W     = EOI_ID_W,
    parameter int NARROW_W = EOI_NARROW_W
) (
    input  logic [ID_W-1:0] raw_id,
    input  logic            wide,
    output id_info_t        info
);

    logic [ID_W-1:0] masked;

    genvar gi;
    generate
        for (gi = 0; gi < ID_W; gi++) begin : g_mask
            if (gi < NARROW_W) begin : g_low
                assign masked[gi] = raw_id[gi];
            end else begin : g_high
                assign masked[gi] = raw_id[gi] & wide;
            end
        end
    endgenerate

    always_comb begin
        info.id      = masked;
        info.special = id_is_special(masked);
    end

endmodule

// File: rtl/eoi_mode_select.sv
module eoi_mode_select
    import eoi_pkg::*;
(
    input  logic [1:0] cur_lvl,
    input  logic       sec_state,
    input  logic       top_present,
    input  logic       mode_plain,
    input  logic       mode_top,
    input  logic       mode_sec,
    input  logic       mode_nsec,
    output logic       drop_only
);

    always_comb begin
        if (!top_present)
            drop_only = mode_plain;
        else if (cur_lvl == TOP_LVL)
            drop_only = mode_top;
        else if (sec_state)
            drop_only = mode_sec;
        else
            drop_only = mode_nsec;
    end

endmodule

// File: rtl/eoi_ack_tracker.sv
module eoi_ack_tracker
    import eoi_pkg::*;
#(
    parameter int ID_W = EOI_ID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ack_take,
    input  logic [ID_W-1:0] ack_id,
    input  logic            wr_accept,
    input  logic [ID_W-1:0] wr_id,
    output logic            mismatch
);

    logic            live_q;
    logic [ID_W-1:0] held_q;

    assign mismatch = wr_accept && (!live_q || (wr_id != held_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            held_q <= '0;
        end else if (ack_take) begin
            live_q <= 1'b1;
            held_q <= ack_id;
        end else if (wr_accept) begin
            live_q <= 1'b0;
        end
    end

    // R10: an accepted write with no new acknowledge leaves nothing tracked
    a_r10_consume: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && !ack_take) |=> !live_q);

    // R10: a fresh acknowledge is tracked on the next cycle
    a_r10_ack_load: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> (live_q && held_q == $past(ack_id)));

endmodule

// File: rtl/eoi_write_ctrl.sv
module eoi_write_ctrl
    import eoi_pkg::*;
#(
    parameter int DATA_W   = EOI_DATA_W,
    parameter int ID_W     = EOI_ID_W,
    parameter int NARROW_W = EOI_NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cur_lvl,
    input  logic              sec_state,
    input  logic              top_present,
    input  logic              id_wide,
    input  logic              mode_plain,
    input  logic              mode_top,
    input  logic              mode_sec,
    input  logic              mode_nsec,
    input  logic              ack_valid,
    input  logic [ID_W-1:0]   ack_id,
    output logic              drop_valid,
    output logic [ID_W-1:0]   drop_id,
    output logic              deact_valid,
    output logic [ID_W-1:0]   deact_id,
    output logic              mismatch_err
);

    id_info_t wr_info;
    id_info_t ack_info;
    logic     drop_only;
    logic     wr_accept;
    logic     ack_take;
    logic     mismatch_now;
    eoi_act_t act_q;
    logic     err_q;

    eoi_id_decode #(.ID_W(ID_W), .NARROW_W(NARROW_W)) u_wr_dec (
        .raw_id (wr_data[ID_W-1:0]),
        .wide   (id_wide),
        .info   (wr_info)
    );

    eoi_id_decode #(.ID_W(ID_W), .NARROW_W(NARROW_W)) u_ack_dec (
        .raw_id (ack_id),
        .wide   (id_wide),
        .info   (ack_info)
    );

    eoi_mode_select u_mode (
        .cur_lvl     (cur_lvl),
        .sec_state   (sec_state),
        .top_present (top_present),
        .mode_plain  (mode_plain),
        .mode_top    (mode_top),
        .mode_sec    (mode_sec),
        .mode_nsec   (mode_nsec),
        .drop_only   (drop_only)
    );

    assign wr_accept = wr_valid && !wr_info.special;
    assign ack_take  = ack_valid && !ack_info.special;

    eoi_ack_tracker #(.ID_W(ID_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .ack_take  (ack_take),
        .ack_id    (ack_info.id),
        .wr_accept (wr_accept),
        .wr_id     (wr_info.id),
        .mismatch  (mismatch_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            err_q <= 1'b0;
        end else begin
            act_q.valid <= wr_accept;
            act_q.deact <= wr_accept && !drop_only;
            act_q.id    <= wr_accept ? wr_info.id : '0;
            if (mismatch_now)
                err_q <= 1'b1;
        end
    end

    assign drop_valid   = act_q.valid;
    assign drop_id      = act_q.id;
    assign deact_valid  = act_q.deact;
    assign deact_id     = act_q.id;
    assign mismatch_err = err_q;

    // R4/R5: a deactivation is always paired with a drop of the same ID
    a_r4_deact_paired: assert property (@(posedge clk) disable iff (rst)
        deact_valid |-> (drop_valid && deact_id == drop_id));

    // R1: a drop strobe only follows a write
    a_r1_follows_write: assert property (@(posedge clk) disable iff (rst)
        drop_valid |-> $past(wr_valid));

    // R8: a special ID never produces a strobe
    a_r8_special_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_info.special) |=> !drop_valid);

    // R3: narrow mode clears the upper ID bits
    a_r3_narrow_zero: assert property (@(posedge clk) disable iff (rst)
        (drop_valid && !$past(id_wide)) |-> (drop_id[ID_W-1:NARROW_W] == '0));

    // R9: the mismatch flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        mismatch_err |=> mismatch_err);

endmodule

// File: tb/sim_eoi_write_ctrl.sv
module sim_eoi_write_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [23:0] ack;
        logic [63:0] data;
        logic        wide;
        logic [1:0]  lvl;
        logic        sec;
        logic        top;
        logic [3:0]  modes;   // [3]=plain [2]=top [1]=sec [0]=nsec
        logic        exp_deact;
        logic [23:0] exp_id;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{24'h000123, 64'h0000000000000123, 1'b1, 2'd1, 1'b0, 1'b0, 4'b0000, 1'b1, 24'h000123},
        '{24'h000045, 64'hFFFFFF0000000045, 1'b1, 2'd1, 1'b0, 1'b0, 4'b1000, 1'b0, 24'h000045},
        '{24'h0A0010, 64'h00000000000A0010, 1'b1, 2'd3, 1'b0, 1'b1, 4'b0100, 1'b0, 24'h0A0010},
        '{24'h0A0011, 64'h00000000000A0011, 1'b1, 2'd3, 1'b1, 1'b1, 4'b1011, 1'b1, 24'h0A0011},
        '{24'h000200, 64'h0000000000000200, 1'b1, 2'd1, 1'b1, 1'b1, 4'b0010, 1'b0, 24'h000200},
        '{24'h000201, 64'h0000000000000201, 1'b1, 2'd1, 1'b0, 1'b1, 4'b0010, 1'b1, 24'h000201},
        '{24'h000202, 64'h0000000000000202, 1'b1, 2'd2, 1'b0, 1'b1, 4'b1101, 1'b0, 24'h000202},
        '{24'h000077, 64'h0000000000AB0077, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0000, 1'b1, 24'h000077}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [63:0] wr_data;
    logic [1:0]  cur_lvl;
    logic        sec_state, top_present, id_wide;
    logic        mode_plain, mode_top, mode_sec, mode_nsec;
    logic        ack_valid;
    logic [23:0] ack_id;
    logic        drop_valid, deact_valid, mismatch_err;
    logic [23:0] drop_id, deact_id;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eoi_write_ctrl u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .cur_lvl(cur_lvl), .sec_state(sec_state), .top_present(top_present),
        .id_wide(id_wide), .mode_plain(mode_plain), .mode_top(mode_top),
        .mode_sec(mode_sec), .mode_nsec(mode_nsec), .ack_valid(ack_valid),
        .ack_id(ack_id), .drop_valid(drop_valid), .drop_id(drop_id),
        .deact_valid(deact_valid), .deact_id(deact_id), .mismatch_err(mismatch_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_ack(input logic [23:0] id);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_id    = id;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // Drives one write; returns at the negedge where the strobes are visible.
    task automatic do_write(input logic [63:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic wide, input logic [1:0] lvl, input logic sec,
                           input logic top, input logic [3:0] m);
        id_wide = wide; cur_lvl = lvl; sec_state = sec; top_present = top;
        {mode_plain, mode_top, mode_sec, mode_nsec} = m;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; ack_valid = 1'b0; ack_id = '0;
        set_cfg(1'b1, 2'd1, 1'b0, 1'b0, 4'b0000);
        do_reset();

        // R11 reset state
        chk("R11 drop_valid", {31'b0, drop_valid}, 0);
        chk("R11 deact_valid", {31'b0, deact_valid}, 0);
        chk("R11 mismatch_err", {31'b0, mismatch_err}, 0);
        chk("R11 drop_id", {8'b0, drop_id}, 0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            set_cfg(VEC[i].wide, VEC[i].lvl, VEC[i].sec, VEC[i].top, VEC[i].modes);
            do_ack(VEC[i].ack);
            do_write(VEC[i].data);
            chk("R1 drop_valid", {31'b0, drop_valid}, 1);
            chk("R2/R3 drop_id", {8'b0, drop_id}, {8'b0, VEC[i].exp_id});
            chk("R4/R5/R6/R7 deact_valid", {31'b0, deact_valid}, {31'b0, VEC[i].exp_deact});
            if (VEC[i].exp_deact)
                chk("R4 deact_id", {8'b0, deact_id}, {8'b0, VEC[i].exp_id});
            chk("R9 no mismatch", {31'b0, mismatch_err}, 0);
            @(negedge clk);
            chk("R1 one-cycle pulse", {30'b0, drop_valid, deact_valid}, 0);
        end

        // R8: special IDs ignored, tracker untouched
        set_cfg(1'b1, 2'd1, 1'b0, 1'b0, 4'b0000);
        do_ack(24'h000100);
        do_write(64'h3FC);
        chk("R8 special no drop", {31'b0, drop_valid}, 0);
        chk("R8 special no err", {31'b0, mismatch_err}, 0);
        set_cfg(1'b0, 2'd1, 1'b0, 1'b0, 4'b0000);
        do_write(64'h0503FF);
        chk("R8 narrow special no drop", {31'b0, drop_valid}, 0);
        set_cfg(1'b1, 2'd1, 1'b0, 1'b0, 4'b0000);
        do_write(64'h100);
        chk("R8 tracker kept drop", {31'b0, drop_valid}, 1);
        chk("R8 tracker kept no err", {31'b0, mismatch_err}, 0);

        // R10: second write after consumption -> mismatch, action still done (R9)
        do_write(64'h100);
        chk("R10 repeat write drop", {31'b0, drop_valid}, 1);
        chk("R10 repeat write err", {31'b0, mismatch_err}, 1);
        @(negedge clk);
        chk("R9 err sticky", {31'b0, mismatch_err}, 1);

        // R9: differing ID
        do_reset();
        chk("R11 err cleared", {31'b0, mismatch_err}, 0);
        do_ack(24'h000200);
        do_write(64'h201);
        chk("R9 mismatch drop", {31'b0, drop_valid}, 1);
        chk("R9 mismatch id", {8'b0, drop_id}, 32'h201);
        chk("R9 mismatch err", {31'b0, mismatch_err}, 1);

        // R10: special acknowledge leaves tracked ID alone
        do_reset();
        do_ack(24'h000300);
        do_ack(24'h0003FE);
        do_write(64'h300);
        chk("R10 special ack ignored", {31'b0, mismatch_err}, 0);
        chk("R10 drop after special ack", {31'b0, drop_valid}, 1);

        // R8: 0x103FC is not special in 24-bit mode (nothing tracked -> mismatch)
        do_write(64'h0103FC);
        chk("R8 wide non-special drop", {31'b0, drop_valid}, 1);
        chk("R8 wide non-special id", {8'b0, drop_id}, 32'h0103FC);
        chk("R10 consumed err", {31'b0, mismatch_err}, 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule